// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

An eight-bit, two-port bus transceiver that couples bus A and bus B, both tri-state bidirectional ports. Each side has its own storage register, loaded from its bus on the rising edge of that side's capture clock. The register on the A side is clocked by `clk_a2b`; the register on the B side is clocked by `clk_b2a`. Capture never stops: it runs whether the outputs are enabled or isolated, and whichever way data flows.

One bus at most is driven. The active-low enable `oe_n` isolates both buses when high. When it is low, `dir` picks the receiving bus. A per-direction select on the driven side chooses between live data from the opposite bus and the word held in the opposite side's register.

A parameter builds an inverting variant. This variant complements both the live path and the stored path on the way out. Its registers still hold the bus value exactly as captured.

The registers have no reset. Their contents are undefined until the first capture.

Top module: `reg_bus_xcvr`

## Requirements
- R1: On every rising edge of `clk_a2b` the A-side register loads the value present on `bus_a`, for any `oe_n` and `dir`, including isolation.
- R2: On every rising edge of `clk_b2a` the B-side register loads the value present on `bus_b`, for any `oe_n` and `dir`, including isolation.
- R3: With `oe_n` = 1 neither `bus_a` nor `bus_b` is driven. Values placed on either bus by another driver read back unchanged.
- R4: With `oe_n` = 0 and `dir` = 0, `bus_a` is driven and `bus_b` is not driven. If `sel_b2a` = 0, `bus_a` carries the live value of `bus_b`.
- R5: With `oe_n` = 0, `dir` = 0 and `sel_b2a` = 1, `bus_a` carries the B-side register contents.
- R6: With `oe_n` = 0 and `dir` = 1, `bus_b` is driven and `bus_a` is not driven. If `sel_a2b` = 0, `bus_b` carries the live value of `bus_a`.
- R7: With `oe_n` = 0, `dir` = 1 and `sel_a2b` = 1, `bus_b` carries the A-side register contents.
- R8: With `INVERT` = 1 every bit on the driven bus is the complement of the live or stored value that R4 to R7 select. The registers hold the uncomplemented bus value, so a stored word of 3C appears as C3.
- R9: While its capture clock stays static, a register holds its word. A stored-mode output stays unchanged while the live source bus changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_a | inout | W | Bus A, tri-state |
| bus_b | inout | W | Bus B, tri-state |
| oe_n | input | 1 | Output enable, active low; high isolates both buses |
| dir | input | 1 | 0: drive bus A; 1: drive bus B |
| clk_a2b | input | 1 | Rising edge captures bus A into the A-side register |
| clk_b2a | input | 1 | Rising edge captures bus B into the B-side register |
| sel_a2b | input | 1 | Source for bus B: 0 live bus A, 1 A-side register |
| sel_b2a | input | 1 | Source for bus A: 0 live bus B, 1 B-side register |

## Verification
Two instances, one plain and one inverting, run side by side on separate bus pairs under the same controls. The stimulus walks through random control combinations with random words on the undriven buses and random capture pulses, so live, stored, isolation and both directions are all visited.

Directed cases cover the following:
- Loading both registers during isolation, then reading each back in stored mode. This separates capture that depends on the enable from capture that is always on.
- Changing the live bus while the stored word is being driven. This separates stored selection from live selection.
- A fixed 3C word through the inverting instance. This shows the inversion sits on the output and not in the register.

On each check the non-driven bus must read back the word the bench placed on it. This exposes any second driver.

// File: rtl/bxr_pkg.sv
package bxr_pkg;
  typedef enum logic [1:0] {
    DRV_NONE = 2'b00,
    DRV_A    = 2'b01,
    DRV_B    = 2'b10
  } drive_e;
endpackage

// File: rtl/bxr_capture.sv
module bxr_capture #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_next;

  // capture is unconditional: every rising edge loads the bus pins
  always_comb q_next = d;

  always_ff @(posedge clk) q <= q_next;
endmodule

// File: rtl/bxr_ctrl.sv
module bxr_ctrl
  import bxr_pkg::*;
(
  input  logic   oe_n,
  input  logic   dir,
  output drive_e drv
);
  always_comb begin
    if (oe_n)     drv = DRV_NONE;
    else if (dir) drv = DRV_B;
    else          drv = DRV_A;
  end
endmodule

// File: rtl/bxr_path.sv
module bxr_path #(
  parameter int W      = 8,
  parameter bit INVERT = 1'b0
) (
  input  logic [W-1:0] live,
  input  logic [W-1:0] stored,
  input  logic         sel,
  output logic [W-1:0] out
);
  logic [W-1:0] picked;

  always_comb picked = sel ? stored : live;

  generate
    if (INVERT) begin : g_inv
      always_comb out = ~picked;
    end else begin : g_pass
      always_comb out = picked;
    end
  endgenerate
endmodule

// File: rtl/reg_bus_xcvr.sv
module reg_bus_xcvr
  import bxr_pkg::*;
#(
  parameter int W      = 8,
  parameter bit INVERT = 1'b0
) (
  inout  wire [W-1:0] bus_a,
  inout  wire [W-1:0] bus_b,
  input  logic        oe_n,
  input  logic        dir,
  input  logic        clk_a2b,
  input  logic        clk_b2a,
  input  logic        sel_a2b,
  input  logic        sel_b2a
);
  logic [W-1:0] store_a;
  logic [W-1:0] store_b;
  logic [W-1:0] out_a;
  logic [W-1:0] out_b;
  drive_e       drv;
  logic         drv_a_en;
  logic         drv_b_en;

  bxr_capture #(.W(W)) u_cap_a (.clk(clk_a2b), .d(bus_a), .q(store_a));
  bxr_capture #(.W(W)) u_cap_b (.clk(clk_b2a), .d(bus_b), .q(store_b));

  bxr_ctrl u_ctrl (.oe_n(oe_n), .dir(dir), .drv(drv));

  always_comb begin
    drv_a_en = (drv == DRV_A);
    drv_b_en = (drv == DRV_B);
  end

  bxr_path #(.W(W), .INVERT(INVERT)) u_to_a (
    .live(bus_b), .stored(store_b), .sel(sel_b2a), .out(out_a)
  );
  bxr_path #(.W(W), .INVERT(INVERT)) u_to_b (
    .live(bus_a), .stored(store_a), .sel(sel_a2b), .out(out_b)
  );

  // one tri-state driver per bit lane on each bus
  generate
    for (genvar i = 0; i < W; i++) begin : g_lane
      assign bus_a[i] = drv_a_en ? out_a[i] : 1'bz;
      assign bus_b[i] = drv_b_en ? out_b[i] : 1'bz;
    end
  endgenerate
endmodule

// File: rtl/bxr_chk.sv
module bxr_chk #(
  parameter int W      = 8,
  parameter bit INVERT = 1'b0
) (
  input logic         clk_a2b,
  input logic         clk_b2a,
  input logic         oe_n,
  input logic         dir,
  input logic         sel_a2b,
  input logic         sel_b2a,
  input logic [W-1:0] bus_a,
  input logic [W-1:0] bus_b,
  input logic [W-1:0] store_a,
  input logic [W-1:0] store_b,
  input logic         drv_a_en,
  input logic         drv_b_en
);
  localparam logic [W-1:0] MASK = INVERT ? {W{1'b1}} : {W{1'b0}};

  bit a_seen, a_ok, b_seen, b_ok;
  always_ff @(posedge clk_a2b) begin
    a_seen <= 1'b1;
    a_ok   <= a_seen;
  end
  always_ff @(posedge clk_b2a) begin
    b_seen <= 1'b1;
    b_ok   <= b_seen;
  end

  // R1
  cap_a_chk: assert property (@(posedge clk_a2b) disable iff (!a_ok)
    store_a == $past(bus_a));
  // R2
  cap_b_chk: assert property (@(posedge clk_b2a) disable iff (!b_ok)
    store_b == $past(bus_b));
  // R3
  isolate_chk: assert property (@(posedge clk_a2b) disable iff (!a_ok)
    oe_n |-> (!drv_a_en && !drv_b_en));
  // R4
  one_bus_chk: assert property (@(posedge clk_b2a) disable iff (!b_ok)
    $onehot0({drv_a_en, drv_b_en}));
  // R5
  stored_to_a_chk: assert property (@(posedge clk_b2a) disable iff (!b_ok)
    (!oe_n && !dir && sel_b2a) |-> (bus_a == (store_b ^ MASK)));
  // R6
  live_to_b_chk: assert property (@(posedge clk_b2a) disable iff (!b_ok)
    (!oe_n && dir && !sel_a2b) |-> (bus_b == (bus_a ^ MASK)));
  // R7
  stored_to_b_chk: assert property (@(posedge clk_a2b) disable iff (!a_ok)
    (!oe_n && dir && sel_a2b) |-> (bus_b == (store_a ^ MASK)));
endmodule

bind reg_bus_xcvr bxr_chk #(.W(W), .INVERT(INVERT)) u_chk (
  .clk_a2b(clk_a2b), .clk_b2a(clk_b2a), .oe_n(oe_n), .dir(dir),
  .sel_a2b(sel_a2b), .sel_b2a(sel_b2a), .bus_a(bus_a), .bus_b(bus_b),
  .store_a(store_a), .store_b(store_b), .drv_a_en(drv_a_en), .drv_b_en(drv_b_en)
);

// File: tb/tb_reg_bus_xcvr.sv
module tb_reg_bus_xcvr;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic oe_n = 1'b1, dir = 1'b0, sel_a2b = 1'b0, sel_b2a = 1'b0;
  logic clk_a2b = 1'b0, clk_b2a = 1'b0;
  logic [7:0] tb_a = 8'h00, tb_b = 8'h00;
  logic tb_a_en = 1'b1, tb_b_en = 1'b1;
  logic [7:0] sa [2];
  logic [7:0] sb [2];
  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  wire [7:0] a0, b0, a1, b1;
  assign a0 = tb_a_en ? tb_a : 8'hzz;
  assign a1 = tb_a_en ? tb_a : 8'hzz;
  assign b0 = tb_b_en ? tb_b : 8'hzz;
  assign b1 = tb_b_en ? tb_b : 8'hzz;

  reg_bus_xcvr #(.W(8), .INVERT(1'b0)) dut (
    .bus_a(a0), .bus_b(b0), .oe_n(oe_n), .dir(dir), .clk_a2b(clk_a2b),
    .clk_b2a(clk_b2a), .sel_a2b(sel_a2b), .sel_b2a(sel_b2a));
  reg_bus_xcvr #(.W(8), .INVERT(1'b1)) dut_inv (
    .bus_a(a1), .bus_b(b1), .oe_n(oe_n), .dir(dir), .clk_a2b(clk_a2b),
    .clk_b2a(clk_b2a), .sel_a2b(sel_a2b), .sel_b2a(sel_b2a));

  function automatic logic [7:0] xf(input logic [7:0] v, input bit inv);
    return inv ? ~v : v;
  endfunction

  function automatic logic [7:0] exp_a(input int k);
    if (tb_a_en) return tb_a;
    return xf(sel_b2a ? sb[k] : tb_b, k == 1);
  endfunction

  function automatic logic [7:0] exp_b(input int k);
    if (tb_b_en) return tb_b;
    return xf(sel_a2b ? sa[k] : tb_a, k == 1);
  endfunction

  function automatic string mode_tag();
    if (oe_n) return "R3";
    if (dir)  return sel_a2b ? "R7" : "R6";
    return sel_b2a ? "R5" : "R4";
  endfunction

  task automatic cmp(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string extra);
    string t;
    t = {mode_tag(), extra};
    cmp({t, " plain bus_a"}, a0, exp_a(0));
    cmp({t, " plain bus_b"}, b0, exp_b(0));
    cmp({t, "/R8 inv bus_a"}, a1, exp_a(1));
    cmp({t, "/R8 inv bus_b"}, b1, exp_b(1));
  endtask

  task automatic set_mode(input logic oe, input logic d, input logic sab,
                          input logic sba, input logic [7:0] va, input logic [7:0] vb);
    @(negedge clk);
    oe_n = oe; dir = d; sel_a2b = sab; sel_b2a = sba;
    tb_a = va; tb_b = vb;
    tb_a_en = oe | d;
    tb_b_en = oe | ~d;
    #4;
  endtask

  // R1: capture A into the bench model at the edge, then pulse
  task automatic pulse_a2b();
    for (int k = 0; k < 2; k++) sa[k] = exp_a(k);
    clk_a2b = 1'b1; #3; clk_a2b = 1'b0; #2;
  endtask

  // R2
  task automatic pulse_b2a();
    for (int k = 0; k < 2; k++) sb[k] = exp_b(k);
    clk_b2a = 1'b1; #3; clk_b2a = 1'b0; #2;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    // Initial state: isolated, bench values read back (R3)
    set_mode(1'b1, 1'b0, 1'b0, 1'b0, 8'h5A, 8'hA5);
    check_all(" initial isolation");

    // R1 R2: load both registers during isolation
    set_mode(1'b1, 1'b1, 1'b1, 1'b1, 8'h3C, 8'h96);
    pulse_a2b(); pulse_b2a();
    check_all(" isolated capture");
    set_mode(1'b0, 1'b1, 1'b1, 1'b0, 8'hFF, 8'h00);
    check_all(" R1 stored A after isolated load");
    cmp("R8 inverted stored word", b1, 8'hC3);
    cmp("R1 plain stored word", b0, 8'h3C);
    set_mode(1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 8'h11);
    check_all(" R2 stored B after isolated load");
    cmp("R2 plain stored word", a0, 8'h96);

    // R9: stored output stable while the live bus moves
    set_mode(1'b0, 1'b1, 1'b1, 1'b0, 8'h01, 8'h00);
    for (int i = 0; i < 4; i++) begin
      tb_a = 8'h01 << (2 * i); #3;
      cmp("R9 stored hold plain", b0, 8'h3C);
      cmp("R9 stored hold inv", b1, 8'hC3);
    end
    set_mode(1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 8'h77);
    tb_b = 8'hE1; #3;
    cmp("R9 stored B hold", a0, 8'h96);

    // R1: capture from the driven bus itself (A driven from live B)
    set_mode(1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h4D);
    pulse_a2b();
    set_mode(1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 8'h00);
    check_all(" R1 capture of driven bus");
    cmp("R1 capture of driven bus plain", b0, 8'h4D);

    // random mix
    for (int it = 0; it < 400; it++) begin
      set_mode(1'(($urandom % 4) == 0), 1'($urandom), 1'($urandom), 1'($urandom),
               8'($urandom), 8'($urandom));
      if ($urandom % 2) pulse_a2b();
      if ($urandom % 2) pulse_b2a();
      check_all(" random");
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule